// File: doc/BRIEF.md
# Justified Stereo Serial Audio Port

This block is the slave side of a stereo serial audio link. An external bit clock and a frame clock arrive as plain inputs and are resampled into the block's own clock domain. The frame clock splits each frame into a left slot, where it is high, and a right slot, where it is low. The transmit and receive words both start at the slot boundary, most significant bit first. On the receive side the block collects one word from each slot. When a frame is complete, it presents the left and right words in parallel with a one-cycle strobe. On the transmit side it shifts two parallel words out serially. A gate input forces the transmit line low so that a zero sample is sent.

The block also checks the frame clock. It counts bit-clock periods in the high and low halves of each frame. When the two counts differ by more than a programmable tolerance, it requests a resynchronisation. It also flags a frame clock edge that arrives in the same sampled cycle as a rising bit clock. The default build carries 16-bit words both ways. Setting `WORD_W` to 18 and `TX_EN` to 0 gives an 18-bit receive-only port. Words are two's complement (7FFFh full positive, 8000h full negative, 0000h zero) and are passed through unchanged.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, `rx_valid`, `resync_req`, `lr_clash` and `sdout` are 0, and `rx_left` and `rx_right` are 0.
- R2: The received word of each slot is made from the first `WORD_W` data bits sampled on rising bit-clock edges after the slot's frame clock edge. The first of these bits is the word's bit `WORD_W-1`. The slot with the frame clock high gives `rx_left` and the slot with it low gives `rx_right`.
- R3: Data bits beyond the first `WORD_W` in a slot do not change the received word.
- R4: `rx_valid` pulses for one cycle when the frame clock rises after a complete left slot and then a right slot. Each frame gives exactly one pulse, and there is no pulse at any other time.
- R5: At each frame clock edge, `sdout` presents bit `WORD_W-1` of `tx_left` (frame clock high) or of `tx_right` (frame clock low). Each following falling bit-clock edge advances `sdout` to the next lower bit.
- R6: Once the `WORD_W` word bits of a slot have been sent, `sdout` stays 0 for the rest of the slot.
- R7: While `tx_gate` is 1, `sdout` is 0, so the word sent is 0000h.
- R8: Together with the `rx_valid` pulse of a frame, `resync_req` is 1 exactly when the high and low halves of that frame differ by more than `duty_tol` rising bit-clock edges. A difference equal to `duty_tol` gives no request.
- R9: `lr_clash` pulses for one cycle when a frame clock edge and a rising bit-clock edge are seen in the same sampled cycle.
- R10: With `WORD_W=18` and `TX_EN=0`, the port receives 18-bit words by the rules of R2, and `sdout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; runs several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame clock; high marks the left slot |
| sdin | input | 1 | Serial playback data in |
| sdout | output | 1 | Serial capture data out |
| tx_gate | input | 1 | Forces `sdout` low while 1 |
| tx_left | input | WORD_W | Left word to transmit |
| tx_right | input | WORD_W | Right word to transmit |
| duty_tol | input | CNT_W | Largest allowed difference, in bit-clock edges, between the two frame halves |
| rx_left | output | WORD_W | Last received left word |
| rx_right | output | WORD_W | Last received right word |
| rx_valid | output | 1 | One-cycle strobe for a new word pair |
| resync_req | output | 1 | Duty error for the frame just completed |
| lr_clash | output | 1 | Frame clock edge coincided with a rising bit clock |

## Verification
Every serial input passes through `SYNC_STAGES` resampling flops and then one edge-detect register. With the default of 2 stages, `rx_valid`, `resync_req`, `lr_clash` and a new `sdout` bit therefore appear on the third clock edge after the bench drives the causing change. The bench holds each bit-clock phase for six clocks. It reads `sdout` at the end of the low phase, just before it raises the bit clock, which is well after a transmit bit is due.

Received pairs and the expected duty verdict are pushed into a queue when a frame is sent. They are popped whenever `rx_valid` appears, whatever cycle that falls on. The clash pulse and the idle `sdout` of the receive-only build are counted by the monitor and compared once the stimulus has settled.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;
   typedef enum logic {CH_RIGHT = 1'b0, CH_LEFT = 1'b1} chan_e;

   // duty verdict: halves differ by more than the tolerance
   function automatic logic duty_off(input int hi, input int lo, input int tol);
      int d;
      d = (hi > lo) ? hi - lo : lo - hi;
      return d > tol;
   endfunction
endpackage

// File: rtl/audio_edge_sync.sv
module audio_edge_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] stg [STAGES];
   logic [N-1:0] prev;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else if (g == 0) stg[g] <= din;
            else stg[g] <= stg[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else prev <= stg[STAGES-1];
   end

   assign lvl  = stg[STAGES-1];
   assign rise = stg[STAGES-1] & ~prev;
   assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              b_rise,
   input  logic              l_rise,
   input  logic              l_fall,
   input  logic              sd,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid
);
   localparam int BIT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] shreg, left_hold;
   logic [BIT_W-1:0]  nbits;
   logic              seen_rise, have_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0; left_hold <= '0; nbits <= '0;
         seen_rise <= 1'b0; have_left <= 1'b0;
         rx_left <= '0; rx_right <= '0; rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (l_rise || l_fall) begin
            if (l_fall && seen_rise) begin
               left_hold <= shreg;
               have_left <= 1'b1;
            end
            if (l_rise) begin
               seen_rise <= 1'b1;
               have_left <= 1'b0;
               if (have_left) begin
                  rx_left  <= left_hold;
                  rx_right <= shreg;
                  rx_valid <= 1'b1;
               end
            end
            shreg <= '0;
            nbits <= '0;
         end else if (b_rise && (nbits < BIT_W'(WORD_W))) begin
            shreg <= {shreg[WORD_W-2:0], sd};
            nbits <= nbits + 1'b1;
         end
      end
   end
endmodule

// File: rtl/audio_tx_ser.sv
module audio_tx_ser
   import audio_port_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              b_fall,
   input  logic              l_edge,
   input  logic              l_lvl,
   input  logic              tx_gate,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   output logic              sdout
);
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else if (l_edge) shreg <= (chan_e'(l_lvl) == CH_LEFT) ? tx_left : tx_right;
      else if (b_fall) shreg <= {shreg[WORD_W-2:0], 1'b0};
   end

   assign sdout = tx_gate ? 1'b0 : shreg[WORD_W-1];
endmodule

// File: rtl/audio_duty_mon.sv
module audio_duty_mon
   import audio_port_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_rise,
   input  logic             l_rise,
   input  logic             l_fall,
   input  logic             l_lvl,
   input  logic [CNT_W-1:0] duty_tol,
   output logic             resync_req
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] hi_cnt, lo_cnt, hi_len;
   logic             seen_rise, hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0; lo_cnt <= '0; hi_len <= '0;
         seen_rise <= 1'b0; hi_ok <= 1'b0; resync_req <= 1'b0;
      end else begin
         resync_req <= 1'b0;
         if (l_rise || l_fall) begin
            if (l_fall) begin
               hi_len <= hi_cnt;
               hi_ok  <= seen_rise;
            end else begin
               seen_rise <= 1'b1;
               hi_ok     <= 1'b0;
               if (hi_ok)
                  resync_req <= duty_off(int'(hi_len), int'(lo_cnt), int'(duty_tol));
            end
            hi_cnt <= '0;
            lo_cnt <= '0;
         end else if (b_rise) begin
            if (l_lvl) hi_cnt <= (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
            else       lo_cnt <= (lo_cnt == CNT_MAX) ? lo_cnt : lo_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
   parameter int WORD_W      = 16,
   parameter bit TX_EN       = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              lrck,
   input  logic              sdin,
   output logic              sdout,
   input  logic              tx_gate,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   input  logic [CNT_W-1:0]  duty_tol,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid,
   output logic              resync_req,
   output logic              lr_clash
);
   generate
      if (WORD_W < 8 || WORD_W > 32) begin : g_bad_word
         $error("WORD_W must lie in 8..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << CNT_W) <= 2 * WORD_W) begin : g_bad_cnt
         $error("CNT_W too narrow for a legal slot");
      end
   endgenerate

   logic [2:0] lvl, rise, fall;
   logic       b_rise, b_fall, l_rise, l_fall, l_lvl, sd;

   audio_edge_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({sdin, lrck, bclk}),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   assign b_rise = rise[0];
   assign b_fall = fall[0];
   assign l_rise = rise[1];
   assign l_fall = fall[1];
   assign l_lvl  = lvl[1];
   assign sd     = lvl[2];

   logic unused_sync;
   assign unused_sync = ^{rise[2], fall[2], lvl[0]};

   audio_rx_deser #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .b_rise(b_rise), .l_rise(l_rise),
      .l_fall(l_fall), .sd(sd), .rx_left(rx_left), .rx_right(rx_right),
      .rx_valid(rx_valid)
   );

   audio_duty_mon #(.CNT_W(CNT_W)) u_duty (
      .clk(clk), .rst_n(rst_n), .b_rise(b_rise), .l_rise(l_rise),
      .l_fall(l_fall), .l_lvl(l_lvl), .duty_tol(duty_tol),
      .resync_req(resync_req)
   );

   generate
      if (TX_EN) begin : g_tx
         audio_tx_ser #(.WORD_W(WORD_W)) u_tx (
            .clk(clk), .rst_n(rst_n), .b_fall(b_fall),
            .l_edge(l_rise | l_fall), .l_lvl(l_lvl), .tx_gate(tx_gate),
            .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout)
         );
      end else begin : g_no_tx
         logic unused_tx;
         assign unused_tx = ^{tx_left, tx_right, tx_gate, b_fall};
         assign sdout = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lr_clash <= 1'b0;
      else lr_clash <= (l_rise | l_fall) & b_rise;
   end
endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_gate,
   input logic sdout,
   input logic rx_valid,
   input logic resync_req,
   input logic lr_clash
);
   assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_gate |-> !sdout);

   assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_resync_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resync_req |-> rx_valid);

   assert_clash_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lr_clash |=> !lr_clash);
endmodule

bind audio_serial_port audio_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_gate(tx_gate), .sdout(sdout),
   .rx_valid(rx_valid), .resync_req(resync_req), .lr_clash(lr_clash)
);

// File: tb/test_audio_serial_port.sv
module test_audio_serial_port;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int W          = 16;
   localparam int W2         = 18;
   localparam int TOL        = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bclk = 1'b0, lrck = 1'b0, sdin = 1'b0, tx_gate = 1'b0;
   logic [W-1:0] tx_left = '0, tx_right = '0;
   logic [7:0] duty_tol = 8'(TOL);
   logic sdout, rx_valid, resync_req, lr_clash;
   logic [W-1:0] rx_left, rx_right;
   logic sdout2, rx_valid2, resync2, clash2;
   logic [W2-1:0] rx_left2, rx_right2;

   audio_serial_port i_audio_serial_port (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdin(sdin),
      .sdout(sdout), .tx_gate(tx_gate), .tx_left(tx_left), .tx_right(tx_right),
      .duty_tol(duty_tol), .rx_left(rx_left), .rx_right(rx_right),
      .rx_valid(rx_valid), .resync_req(resync_req), .lr_clash(lr_clash)
   );

   audio_serial_port #(.WORD_W(W2), .TX_EN(1'b0)) i_audio_serial_port_rx18 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdin(sdin),
      .sdout(sdout2), .tx_gate(tx_gate), .tx_left('0), .tx_right('0),
      .duty_tol(duty_tol), .rx_left(rx_left2), .rx_right(rx_right2),
      .rx_valid(rx_valid2), .resync_req(resync2), .lr_clash(clash2)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, clash_seen = 0, sd2_seen = 0;
   bit ignore_rx = 1'b0;
   logic [W-1:0]  q_l[$], q_r[$];
   bit            q_rs[$];
   logic [W2-1:0] q2_l[$], q2_r[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: scoreboard pops on every strobe
   always @(negedge clk) if (rst_n) begin
      if (lr_clash) clash_seen++;
      if (sdout2) sd2_seen++;
      if (!ignore_rx) begin
         if (rx_valid) begin
            if (q_l.size() == 0) check(1'b0, "R4", "unexpected valid", 1, 0);
            else begin
               logic [W-1:0] el, er; bit ers;
               el = q_l.pop_front(); er = q_r.pop_front(); ers = q_rs.pop_front();
               check(rx_left == el, "R2", "left word", 32'(rx_left), 32'(el));
               check(rx_right == er, "R3", "right word", 32'(rx_right), 32'(er));
               check(resync_req == ers, "R8", "resync verdict", 32'(resync_req), 32'(ers));
            end
         end else if (resync_req) check(1'b0, "R8", "resync without frame", 1, 0);
         if (rx_valid2) begin
            if (q2_l.size() == 0) check(1'b0, "R10", "unexpected valid", 1, 0);
            else begin
               logic [W2-1:0] el2, er2;
               el2 = q2_l.pop_front(); er2 = q2_r.pop_front();
               check(rx_left2 == el2, "R10", "18-bit left", 32'(rx_left2), 32'(el2));
               check(rx_right2 == er2, "R10", "18-bit right", 32'(rx_right2), 32'(er2));
            end
         end
      end
   end

   task automatic slot(input bit lvl, input logic [W-1:0] word, input int nbits,
                       input logic [W-1:0] txexp, input string req);
      logic [W-1:0] got; bit extra_bad;
      got = '0; extra_bad = 1'b0;
      lrck = lvl;
      for (int i = 0; i < nbits; i++) begin
         bclk = 1'b0;
         sdin = (i < W) ? word[W-1-i] : 1'b1;   // filler ones beyond the word
         repeat (HALF) @(negedge clk);
         if (i < W) got[W-1-i] = sdout;
         else if (sdout) extra_bad = 1'b1;
         bclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      check(got == txexp, req, "transmitted word", 32'(got), 32'(txexp));
      check(!extra_bad, "R6", "bits after word", 32'(extra_bad), 0);
   endtask

   task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r,
                        input int hi, input int lo, input bit g);
      logic [W-1:0] tl, tr; int d;
      tl = ~l; tr = {r[7:0], r[15:8]};
      tx_left = tl; tx_right = tr; tx_gate = g;
      d = (hi > lo) ? hi - lo : lo - hi;
      q_l.push_back(l); q_r.push_back(r); q_rs.push_back(d > TOL);
      q2_l.push_back({l, 2'b11}); q2_r.push_back({r, 2'b11});
      slot(1'b1, l, hi, g ? '0 : tl, g ? "R7" : "R5");
      slot(1'b0, r, lo, g ? '0 : tr, g ? "R7" : "R5");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rx_valid == 0 && resync_req == 0 && lr_clash == 0, "R1", "strobes", 0, 0);
      check(sdout == 0, "R1", "sdout", 32'(sdout), 0);
      check(rx_left == 0 && rx_right == 0, "R1", "words", 32'(rx_left), 0);
      frame(16'h1234, 16'hABCD, 32, 32, 1'b0);
      frame(16'h7FFF, 16'h8000, 32, 36, 1'b0);   // diff 4: resync
      frame(16'h0000, 16'hFFFF, 34, 32, 1'b0);   // diff 2: at limit
      frame(16'hA5A5, 16'h5A5A, 35, 32, 1'b0);   // diff 3: resync
      frame(16'h8001, 16'h7FFE, 32, 32, 1'b1);   // gated transmit
      frame(16'h0F0F, 16'hF0F0, 33, 33, 1'b0);
      tx_gate = 1'b0;
      lrck = 1'b1; bclk = 1'b0;                  // closing edge ends last frame
      repeat (20) @(negedge clk);
      check(q_l.size() == 0, "R4", "frames left unstrobed", q_l.size(), 0);
      check(q2_l.size() == 0, "R10", "18-bit frames left", q2_l.size(), 0);
      check(sd2_seen == 0, "R10", "receive-only sdout high", sd2_seen, 0);
      check(clash_seen == 0, "R9", "clash on legal timing", clash_seen, 0);
      ignore_rx = 1'b1;
      lrck = 1'b0; bclk = 1'b1;                  // illegal coincident edge
      repeat (20) @(negedge clk);
      check(clash_seen == 1, "R9", "clash pulses", clash_seen, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule